// File: doc/BRIEF.md
# Serial Grant Chain Bus Arbiter

This block arbitrates a shared bus among a parameterised set of masters, any of which may be a processor or a DMA engine. Every master drives its own request bit; the block merges them into one shared request seen by a central controller. When the bus is idle and the shared request is active, the controller produces a registered grant. That grant enters the first stage of a chain and passes stage by stage toward the far end. The first stage whose master is requesting keeps the grant, so later stages never see it.

Priority therefore comes only from position. Index 0 sits next to the controller and always wins over higher indices. The winning master holds the bus, and the block holds the shared busy line, until that master drops its request. Requests raised while the bus is held wait for the release. The controller then looks at the shared request again and issues the next grant.

Top module: `daisy_grant_arb`

## Requirements
- R1: `req_any` is high in exactly those cycles in which at least one bit of `req` is high.
- R2: The controller issues a grant only while `busy` is low. With the bus idle, a request present at a clock edge produces a grant in the cycle that follows that edge.
- R3: A new grant goes to the requesting master with the lowest index. Index 0 is the stage nearest the controller.
- R4: At most one bit of `gnt` is high in any cycle. A `gnt` bit is high only while the matching `req` bit is high, so `gnt` is zero when no master requests.
- R5: `busy` rises in the cycle after a master takes a grant and stays high while that master keeps its request.
- R6: While a master holds the bus, new requests from any other master, including higher-priority ones, do not move the grant.
- R7: When the owner drops its request, its `gnt` bit falls in the same cycle and `busy` falls one cycle later. A waiting master receives its grant in the cycle after that.
- R8: After reset, `gnt` is all zero and `busy` is low.
- R9: Every position in the chain can win the bus when it is the only requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | Per-master bus request; bit 0 is nearest the controller |
| gnt | output | NUM_MASTERS | One-hot per-master grant |
| busy | output | 1 | Shared bus-held line |
| req_any | output | 1 | Shared request line, OR of all requests |

## Verification
The hardest case to reach is a higher-priority master raising its request while a lower-priority master already holds the bus. The grant must stay put, and only after the release does the priority order decide again. The stimulus gives master 1 the bus first and then asserts master 0. It checks over several cycles that nothing moves, then drops master 1's request and checks the one-cycle gap on `busy` before master 0 takes over.

// File: rtl/daisy_grant_arb.sv
module daisy_grant_arb #(
  parameter int unsigned NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   busy,
  output logic                   req_any
);
  localparam int unsigned N = NUM_MASTERS;

  logic         ctl_gnt;
  logic [N-1:0] chain_in;
  logic [N-1:0] take;
  logic [N-1:0] hold;

  assign req_any     = |req;
  assign busy        = |hold;
  assign chain_in[0] = ctl_gnt;

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i > 0) begin : g_pass
      assign chain_in[i] = chain_in[i-1] & ~req[i-1];
    end
    assign take[i] = chain_in[i] & req[i];
  end

  assign gnt = take | (hold & req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_gnt <= 1'b0;
      hold    <= '0;
    end else begin
      ctl_gnt <= req_any & ~busy & ~ctl_gnt;
      hold    <= take | (hold & req);
    end
  end

  // R4
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R4
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R2
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ctl_gnt);
  // R3
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_gnt |-> gnt == (req & (~req + 1'b1)));
  // R5
  busy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && !busy) |=> busy);
  // R6
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && |(hold & req)) |=> hold == $past(hold));
  // R7
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> gnt == '0);
endmodule

// File: tb/daisy_grant_arb_tb.sv
`timescale 1ns/1ps
module daisy_grant_arb_tb;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic busy, req_any;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  daisy_grant_arb #(.NUM_MASTERS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .gnt(gnt), .busy(busy), .req_any(req_any)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic go_idle();
    req = '0;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    check("R8 gnt", gnt, 0);
    check("R8 busy", busy, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_each_position();
    for (int i = 0; i < N; i++) begin
      req = 4'(1 << i);
      #1;
      check("R1 req_any", req_any, 1);
      check("R2 no grant before edge", gnt, 0);
      tick();
      check("R9 single winner", gnt, 32'(1 << i));
      tick();
      check("R5 busy", busy, 1);
      go_idle();
      check("R4 idle gnt", gnt, 0);
      check("R1 req_any idle", req_any, 0);
    end
  endtask

  task automatic t_priority();
    req = 4'b1010;
    tick();
    check("R3 lowest of 1010", gnt, 4'b0010);
    go_idle();
    req = 4'b1100;
    tick();
    check("R3 lowest of 1100", gnt, 4'b0100);
    go_idle();
    req = 4'b1111;
    tick();
    check("R3 lowest of 1111", gnt, 4'b0001);
    go_idle();
  endtask

  task automatic t_hold_release();
    req = 4'b0010;
    tick();
    tick();
    check("R5 busy held", busy, 1);
    req = 4'b0011;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R6 grant stays", gnt, 4'b0010);
      check("R6 busy stays", busy, 1);
    end
    req = 4'b0001;
    #1;
    check("R7 gnt drops", gnt, 0);
    check("R7 busy still", busy, 1);
    tick();
    check("R7 busy falls", busy, 0);
    check("R7 gap", gnt, 0);
    tick();
    check("R7 waiter wins", gnt, 4'b0001);
    go_idle();
  endtask

  initial begin
    t_reset();
    t_each_position();
    t_priority();
    t_hold_release();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog got=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule